// File: doc/BRIEF.md
# Two-Stage 4x4 Matrix Transpose Pipeline

This block transposes a 4x4 matrix of data words in a two-stage pipeline. The matrix arrives as four row vectors of four lanes each, packed into one wide input, together with a valid tag. Each stage builds every output row by picking lanes from exactly two input rows. Four such two-row swizzles per stage give eight in total, and no stage uses a full 16-way crossbar.

The first stage pairs adjacent rows (0 with 1, 2 with 3). It transposes the 2x2 corner sub-blocks of the matrix. The second stage pairs rows two apart (0 with 2, 1 with 3) and moves the off-diagonal quadrants into place to finish the transpose. Both stages are registered. A matrix enters every cycle and leaves two cycles later with its valid tag.

The block only rearranges words. It never alters their values.

Top module: `mat4_transpose2`

## Requirements
- R1: Element (r, l) of a matrix is the DATA_W-bit field at bit offset (r*4 + l)*DATA_W, where r is the row and l is the lane. For every i and j, output element (i, j) equals input element (j, i) of the matrix accepted two cycles earlier.
- R2: A matrix presented with in_valid high at rising edge N appears on out_matrix with out_valid high after rising edge N+2. out_valid is low after any edge N+2 whose edge N saw in_valid low.
- R3: Matrices presented on consecutive cycles leave on consecutive cycles, in arrival order. Gaps in in_valid reappear unchanged in out_valid.
- R4: While rst is high at a rising edge (synchronous reset), both stage valids and both stage data registers clear. out_valid is then 0 and out_matrix is all zeros.
- R5: While in_valid is low, the stage data registers keep their contents, and in_matrix has no effect. out_matrix keeps showing the last transposed matrix.
- R6: A reset during flight discards any matrices still in the pipeline. None of them raises out_valid after reset is released.
- R7: A symmetric input matrix comes out unchanged, and uniform all-zero and all-one matrices pass through intact.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input matrix is valid this cycle |
| in_matrix | input | 16*DATA_W | Input matrix: four rows of four lanes, element (r,l) at (r*4+l)*DATA_W |
| out_valid | output | 1 | Output matrix is valid this cycle |
| out_matrix | output | 16*DATA_W | Transposed matrix in the same layout |

## Verification
The bench builds the block with DATA_W set to 12 rather than the default 32. This width is not a power of two and is not byte-aligned, so any slice that uses a wrong stride or base offset shifts bits across element boundaries and shows up in the output. Each element is generated from its own row and lane, so every misrouted element in both swizzle stages gives a distinct, detectable value.

// File: rtl/mat4_pkg.sv
package mat4_pkg;

    localparam int unsigned DIM = 4;

    typedef enum logic [0:0] {
        ST_QUADRANT = 1'b0,   // pair adjacent rows, transpose 2x2 corners
        ST_FINISH   = 1'b1    // pair rows two apart, settle quadrants
    } stage_kind_e;

    // first source row feeding output row k
    function automatic int unsigned src_lo(stage_kind_e kind, int unsigned k);
        return (kind == ST_QUADRANT) ? 2 * (k / 2) : (k % 2);
    endfunction

    // second source row feeding output row k
    function automatic int unsigned src_hi(stage_kind_e kind, int unsigned k);
        return (kind == ST_QUADRANT) ? 2 * (k / 2) + 1 : (k % 2) + 2;
    endfunction

    // lane l of output row k is taken from the second source row when 1
    function automatic bit pick_hi(stage_kind_e kind, int unsigned k, int unsigned l);
        return (kind == ST_QUADRANT) ? bit'(l % 2) : bit'(l / 2);
    endfunction

    // source lane for lane l of output row k
    function automatic int unsigned pick_lane(stage_kind_e kind, int unsigned k, int unsigned l);
        return (kind == ST_QUADRANT) ? 2 * (l / 2) + (k % 2) : 2 * (k / 2) + (l % 2);
    endfunction

endpackage

// File: rtl/row_pair_swizzle.sv
module row_pair_swizzle #(
    parameter int unsigned          W    = 32,
    parameter mat4_pkg::stage_kind_e KIND = mat4_pkg::ST_QUADRANT,
    parameter int unsigned          ROW  = 0
) (
    input  logic [mat4_pkg::DIM*W-1:0] row_lo,
    input  logic [mat4_pkg::DIM*W-1:0] row_hi,
    output logic [mat4_pkg::DIM*W-1:0] row_out
);
    import mat4_pkg::*;

    for (genvar l = 0; l < DIM; l++) begin : g_lane
        localparam bit          TAKE_HI = pick_hi(KIND, ROW, l);
        localparam int unsigned SRC_LN  = pick_lane(KIND, ROW, l);
        if (TAKE_HI) begin : g_hi
            assign row_out[l*W +: W] = row_hi[SRC_LN*W +: W];
        end else begin : g_lo
            assign row_out[l*W +: W] = row_lo[SRC_LN*W +: W];
        end
    end

endmodule

// File: rtl/swizzle_stage.sv
module swizzle_stage #(
    parameter int unsigned          W    = 32,
    parameter mat4_pkg::stage_kind_e KIND = mat4_pkg::ST_QUADRANT
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 in_vld,
    input  logic [mat4_pkg::DIM*mat4_pkg::DIM*W-1:0] in_mat,
    output logic                                 out_vld,
    output logic [mat4_pkg::DIM*mat4_pkg::DIM*W-1:0] out_mat
);
    import mat4_pkg::*;

    localparam int unsigned ROW_W = DIM * W;
    localparam int unsigned MAT_W = DIM * ROW_W;

    typedef struct packed {
        logic             vld;
        logic [MAT_W-1:0] mat;
    } stage_st_t;

    stage_st_t        st_d, st_q;
    logic [MAT_W-1:0] swz_mat;

    for (genvar k = 0; k < DIM; k++) begin : g_row
        localparam int unsigned LO = src_lo(KIND, k);
        localparam int unsigned HI = src_hi(KIND, k);
        row_pair_swizzle #(
            .W    (W),
            .KIND (KIND),
            .ROW  (k)
        ) u_swz (
            .row_lo  (in_mat[LO*ROW_W +: ROW_W]),
            .row_hi  (in_mat[HI*ROW_W +: ROW_W]),
            .row_out (swz_mat[k*ROW_W +: ROW_W])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_vld;
        if (in_vld) begin
            st_d.mat = swz_mat;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_vld = st_q.vld;
    assign out_mat = st_q.mat;

    a_r2_valid_forward: assert property (@(posedge clk) disable iff (rst)
        in_vld |=> out_vld);
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> !out_vld);
    a_r5_data_hold: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> $stable(out_mat));
    a_r4_reset_clear: assert property (@(posedge clk)
        rst |=> (!out_vld && out_mat == '0));

endmodule

// File: rtl/mat4_transpose2.sv
module mat4_transpose2 #(
    parameter int unsigned DATA_W = 32
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  logic [16*DATA_W-1:0]   in_matrix,
    output logic                   out_valid,
    output logic [16*DATA_W-1:0]   out_matrix
);
    import mat4_pkg::*;

    localparam int unsigned MAT_W = DIM * DIM * DATA_W;

    logic             mid_vld;
    logic [MAT_W-1:0] mid_mat;

    swizzle_stage #(
        .W    (DATA_W),
        .KIND (ST_QUADRANT)
    ) u_stage_quad (
        .clk     (clk),
        .rst     (rst),
        .in_vld  (in_valid),
        .in_mat  (in_matrix),
        .out_vld (mid_vld),
        .out_mat (mid_mat)
    );

    swizzle_stage #(
        .W    (DATA_W),
        .KIND (ST_FINISH)
    ) u_stage_finish (
        .clk     (clk),
        .rst     (rst),
        .in_vld  (mid_vld),
        .in_mat  (mid_mat),
        .out_vld (out_valid),
        .out_mat (out_matrix)
    );

    // plain index-swap model, independent of the swizzle tables
    function automatic logic [MAT_W-1:0] flip(input logic [MAT_W-1:0] m);
        logic [MAT_W-1:0] t;
        t = '0;
        for (int i = 0; i < DIM; i++) begin
            for (int j = 0; j < DIM; j++) begin
                t[(i*DIM+j)*DATA_W +: DATA_W] = m[(j*DIM+i)*DATA_W +: DATA_W];
            end
        end
        return t;
    endfunction

    a_r1_transpose: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_matrix == flip($past(in_matrix, 2))));
    a_r3_pipe_order: assert property (@(posedge clk) disable iff (rst)
        mid_vld |=> out_valid);

endmodule

// File: tb/mat4_transpose2_test.sv
`timescale 1ns/1ps
module mat4_transpose2_test;

    localparam int unsigned DW  = 12;
    localparam int unsigned MW  = 16 * DW;
    localparam int unsigned NTAB = 6;

    typedef struct packed {
        logic [DW-1:0] base;
        logic [DW-1:0] step;
        logic [DW-1:0] mask;
    } pat_t;

    // stimulus recipes; expected result is the index swap of each
    localparam pat_t TAB [NTAB] = '{
        '{12'h001, 12'h001, 12'h000},
        '{12'h100, 12'h011, 12'h000},
        '{12'h5A5, 12'h0D3, 12'hA5A},
        '{12'h800, 12'h101, 12'h3C3},
        '{12'h000, 12'h000, 12'h000},
        '{12'hFFF, 12'h000, 12'h000}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [MW-1:0] in_matrix = '0;
    logic          out_valid;
    logic [MW-1:0] out_matrix;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    mat4_transpose2 #(.DATA_W(DW)) uut (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_matrix  (in_matrix),
        .out_valid  (out_valid),
        .out_matrix (out_matrix)
    );

    function automatic logic [MW-1:0] build(pat_t p);
        logic [MW-1:0] m;
        for (int e = 0; e < 16; e++) begin
            m[e*DW +: DW] = DW'(p.base + p.step * DW'(e)) ^ p.mask;
        end
        return m;
    endfunction

    function automatic logic [MW-1:0] swap_ix(logic [MW-1:0] m);
        logic [MW-1:0] t;
        for (int i = 0; i < 4; i++) begin
            for (int j = 0; j < 4; j++) begin
                t[(i*4+j)*DW +: DW] = m[(j*4+i)*DW +: DW];
            end
        end
        return t;
    endfunction

    task automatic chk(string tag, logic [MW-1:0] act, logic [MW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    initial begin
        logic [MW-1:0] last;
        logic [MW-1:0] sym;
        logic [MW-1:0] a;
        logic [MW-1:0] b;
        repeat (3) @(negedge clk);
        // R4: reset state
        chk("R4 reset valid", MW'(out_valid), '0);
        chk("R4 reset data", out_matrix, '0);
        rst = 1'b0;

        // R1 R2 R3 R7: back-to-back stream from the table
        for (int i = 0; i < NTAB + 2; i++) begin
            @(negedge clk);
            if (i >= 2) begin
                chk("R3 stream valid", MW'(out_valid), MW'(1));
                chk("R1 stream data", out_matrix, swap_ix(build(TAB[i-2])));
            end
            if (i < NTAB) begin
                in_valid  = 1'b1;
                in_matrix = build(TAB[i]);
            end else begin
                in_valid  = 1'b0;
            end
        end
        last = swap_ix(build(TAB[NTAB-1]));

        // R5: in_valid low, changing data has no effect
        for (int i = 0; i < 4; i++) begin
            in_matrix = build('{DW'(12'h3A1 + i), 12'h017, 12'h0F0});
            @(negedge clk);
            chk("R5 hold valid", MW'(out_valid), '0);
            chk("R5 hold data", out_matrix, last);
        end

        // R2: single matrix latency
        a = build('{12'h0A0, 12'h00B, 12'h001});
        in_valid = 1'b1; in_matrix = a;
        @(negedge clk);
        in_valid = 1'b0; in_matrix = '1;
        chk("R2 one edge not yet", MW'(out_valid), '0);
        @(negedge clk);
        chk("R2 two edges valid", MW'(out_valid), MW'(1));
        chk("R1 single data", out_matrix, swap_ix(a));
        @(negedge clk);
        chk("R2 drop after", MW'(out_valid), '0);

        // R3: gapped pattern valid, idle, valid
        a = build('{12'h111, 12'h222, 12'h000});
        b = build('{12'hC0C, 12'h035, 12'h707});
        in_valid = 1'b1; in_matrix = a;
        @(negedge clk);
        in_valid = 1'b0; in_matrix = b;
        @(negedge clk);
        in_valid = 1'b1;
        chk("R3 gap first out", out_matrix, swap_ix(a));
        chk("R3 gap first valid", MW'(out_valid), MW'(1));
        @(negedge clk);
        in_valid = 1'b0;
        chk("R3 gap hole", MW'(out_valid), '0);
        @(negedge clk);
        chk("R3 gap second valid", MW'(out_valid), MW'(1));
        chk("R3 gap second out", out_matrix, swap_ix(b));

        // R7: symmetric matrix passes unchanged
        for (int r = 0; r < 4; r++) begin
            for (int l = 0; l < 4; l++) begin
                sym[(r*4+l)*DW +: DW] = DW'(12'h40 * (r + l) + r * l);
            end
        end
        in_valid = 1'b1; in_matrix = sym;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        chk("R7 symmetric", out_matrix, sym);

        // R6: reset while two matrices are in flight
        in_valid = 1'b1; in_matrix = a;
        @(negedge clk);
        in_matrix = b;
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R6 reset data", out_matrix, '0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R6 flushed valid", MW'(out_valid), '0);
        end

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule